// File: doc/BRIEF.md
# Phased SPI Master Transaction Sequencer

This block is an SPI master that performs one complete transaction for each start pulse. A transaction is assembled from up to five optional segments, always issued in a fixed sequence: an opcode field, an address field, a run of idle (dummy) clocks, an outgoing data stream and an incoming data stream. Each segment has its own enable and its own programmed length. A full-duplex option merges the two data streams into one segment, during which bits are shifted out and captured at the same time.

All settings are captured on the accepted start pulse, so software may change them while a transaction runs. The serial clock rate comes from an integer divider of the system clock, and its polarity and phase are selectable. Outgoing data is fetched word by word from an external buffer through an index/data port. Incoming bits are packed into words and handed out with a write strobe and a word index.

Top module: `spi_phase_master`

## Requirements
- R1: Enabled segments run strictly in the sequence opcode, address, dummy, outgoing data, incoming data, and a disabled segment adds no serial clocks; a start with no segment enabled gives a `done` pulse on the next cycle with `cs_n` never asserted and no SCLK edges.
- R2: With `cmd_en`=1 the opcode segment lasts `cmd_len_m1`+1 bits (1 to 16). It sends the low bits of `cmd_val` on MOSI, starting from bit `cmd_len_m1` and ending at bit 0.
- R3: With `addr_en`=1 the address segment lasts `addr_len_m1`+1 bits (1 to 32). It sends `addr_val` MSB first in the same way, starting from bit `addr_len_m1`.
- R4: With `dummy_en`=1 the dummy segment lasts `dummy_len_m1`+1 SCLK periods (1 to 256), with MOSI held at 0 and MISO not stored.
- R5: With `tx_en`=1 the outgoing segment lasts `tx_len_m1`+1 bits (1 to 512). Bit n is taken from buffer word `tx_word_idx`=n/32, at bit position 31-(n mod 32). MOSI is 0 in every segment that sends nothing.
- R6: With `rx_en`=1 and no full duplex, the incoming segment lasts `rx_len_m1`+1 bits with MOSI at 0. Captured MISO bits are shifted in at bit 0 of a 32-bit word. The block pulses `rx_wr_en` for one cycle with `rx_word_idx`=n/32 after the 32nd bit of a word or after the final bit, so a final partial word is right-aligned.
- R7: When `full_duplex`, `tx_en` and `rx_en` are all 1, the incoming segment is replaced by capture during the outgoing segment. That segment lasts `tx_len_m1`+1 bits, and `rx_len_m1` has no effect.
- R8: `cs_n` goes low when the first segment starts and stays low until the last one ends. SCLK rests at `cpol` while `cs_n` is high and makes exactly two transitions per bit period.
- R9: MISO is sampled and MOSI is observed on the rising SCLK edge when `cpol` equals `cpha`, and on the falling edge otherwise. MOSI changes only on the opposite edge.
- R10: Each SCLK half period lasts `clk_div`+1 system clock cycles, so a transaction of N bit periods keeps `busy` high for exactly 2·(`clk_div`+1)·N cycles.
- R11: `busy` rises on the cycle after an accepted start and falls on the cycle in which `done` pulses for one cycle. A start pulse while busy is ignored, and the settings captured at the start stay in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches a transaction when idle |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| cmd_en | input | 1 | Opcode segment enable |
| cmd_len_m1 | input | 4 | Opcode length minus one |
| cmd_val | input | 16 | Opcode value |
| addr_en | input | 1 | Address segment enable |
| addr_len_m1 | input | 5 | Address length minus one |
| addr_val | input | 32 | Address value |
| dummy_en | input | 1 | Dummy segment enable |
| dummy_len_m1 | input | 8 | Dummy clock count minus one |
| tx_en | input | 1 | Outgoing data enable |
| tx_len_m1 | input | 9 | Outgoing bit count minus one |
| rx_en | input | 1 | Incoming data enable |
| rx_len_m1 | input | 9 | Incoming bit count minus one |
| full_duplex | input | 1 | Capture during the outgoing segment |
| clk_div | input | 8 | SCLK half period minus one, in system clocks |
| cpol | input | 1 | SCLK idle level |
| cpha | input | 1 | SCLK phase select |
| tx_word_idx | output | 4 | Index of the outgoing buffer word |
| tx_word | input | 32 | Outgoing buffer word at `tx_word_idx` |
| rx_wr_en | output | 1 | Incoming word write strobe |
| rx_word_idx | output | 4 | Index of the incoming word |
| rx_word | output | 32 | Incoming word value |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
On every cycle the assertions check that the segment pointer never moves backwards, that the bit counter stays within the current segment's length, that SCLK only moves on divider ticks, that the divider count stays in range, that incoming word strobes never fall on adjacent cycles, and that the end of busy coincides with `done` and a rising `cs_n`. A start during a transaction must leave the captured settings unchanged. The actual bit streams can only be shown by the bench's scenarios. These cover MSB-first field order, zeros during dummy and receive segments, word packing with right-aligned tails, full duplex with the receive length ignored, the sampling edge in all four clock modes, and the exact transaction length in system cycles.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  typedef enum logic [2:0] {
    SEG_CMD   = 3'd0,
    SEG_ADDR  = 3'd1,
    SEG_DUMMY = 3'd2,
    SEG_TX    = 3'd3,
    SEG_RX    = 3'd4,
    SEG_NONE  = 3'd5
  } seg_e;

  // First enabled segment whose position is at or after 'from'.
  function automatic seg_e first_seg(input logic [4:0] en, input int from);
    seg_e s;
    s = SEG_NONE;
    for (int k = 4; k >= 0; k--) begin
      if (en[k] && (k >= from)) s = seg_e'(3'(k));
    end
    return s;
  endfunction

endpackage

// File: rtl/spi_seq_clkgen.sv
module spi_seq_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == div);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_cnt_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= div));

endmodule

// File: rtl/spi_seq_rxpack.sv
module spi_seq_rxpack #(
  parameter int BIT_W  = 9,
  parameter int WORD_W = 32,
  localparam int WBIT_W = $clog2(WORD_W),
  localparam int WIDX_W = BIT_W - WBIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic              miso,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic              last,
  output logic              wr_en,
  output logic [WIDX_W-1:0] wr_idx,
  output logic [WORD_W-1:0] wr_word
);

  logic [WORD_W-1:0] sh_q, sh_d, sh_next;
  logic              wr_q, wr_d;
  logic [WIDX_W-1:0] idx_q, idx_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              word_start, word_end;

  assign word_start = (bit_idx[WBIT_W-1:0] == '0);
  assign word_end   = (&bit_idx[WBIT_W-1:0]) || last;
  assign sh_next    = word_start ? {{(WORD_W-1){1'b0}}, miso}
                                 : {sh_q[WORD_W-2:0], miso};

  always_comb begin
    sh_d   = sh_q;
    wr_d   = 1'b0;
    idx_d  = idx_q;
    word_d = word_q;
    if (sample) begin
      sh_d = sh_next;
      if (word_end) begin
        wr_d   = 1'b1;
        word_d = sh_next;
        idx_d  = bit_idx[BIT_W-1:WBIT_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      wr_q   <= 1'b0;
      idx_q  <= '0;
      word_q <= '0;
    end else begin
      sh_q   <= sh_d;
      wr_q   <= wr_d;
      idx_q  <= idx_d;
      word_q <= word_d;
    end
  end

  assign wr_en   = wr_q;
  assign wr_idx  = idx_q;
  assign wr_word = word_q;

  assert_rx_strobe_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |=> !wr_q);

endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_seq_pkg::*;
#(
  parameter int CMD_MAX   = 16,
  parameter int ADDR_MAX  = 32,
  parameter int DUMMY_MAX = 256,
  parameter int DATA_MAX  = 512,
  parameter int WORD_W    = 32,
  parameter int DIV_W     = 8,
  localparam int CMD_LW   = $clog2(CMD_MAX),
  localparam int ADDR_LW  = $clog2(ADDR_MAX),
  localparam int DUMMY_LW = $clog2(DUMMY_MAX),
  localparam int DATA_LW  = $clog2(DATA_MAX),
  localparam int BIT_W    = DATA_LW,
  localparam int WBIT_W   = $clog2(WORD_W),
  localparam int WIDX_W   = BIT_W - WBIT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                cmd_en,
  input  logic [CMD_LW-1:0]   cmd_len_m1,
  input  logic [CMD_MAX-1:0]  cmd_val,
  input  logic                addr_en,
  input  logic [ADDR_LW-1:0]  addr_len_m1,
  input  logic [ADDR_MAX-1:0] addr_val,
  input  logic                dummy_en,
  input  logic [DUMMY_LW-1:0] dummy_len_m1,
  input  logic                tx_en,
  input  logic [DATA_LW-1:0]  tx_len_m1,
  input  logic                rx_en,
  input  logic [DATA_LW-1:0]  rx_len_m1,
  input  logic                full_duplex,
  input  logic [DIV_W-1:0]    clk_div,
  input  logic                cpol,
  input  logic                cpha,
  input  logic                tick,
  input  logic [WORD_W-1:0]   tx_word,
  output logic [DIV_W-1:0]    div_o,
  output logic                run_o,
  output logic                done_o,
  output logic                cs_n_o,
  output logic                sclk_o,
  output logic                mosi_o,
  output logic [WIDX_W-1:0]   tx_idx_o,
  output logic                sample_o,
  output logic [BIT_W-1:0]    rx_bit_o,
  output logic                rx_last_o
);

  // Captured settings
  logic [CMD_LW-1:0]   cmd_len_q;
  logic [CMD_MAX-1:0]  cmd_val_q;
  logic [ADDR_LW-1:0]  addr_len_q;
  logic [ADDR_MAX-1:0] addr_val_q;
  logic [DUMMY_LW-1:0] dummy_len_q;
  logic [DATA_LW-1:0]  tx_len_q, rx_len_q;
  logic [4:0]          en_q;
  logic                fd_q, cpol_q, cpha_q;
  logic [DIV_W-1:0]    div_q;

  // Sequencing state
  logic             run_q, run_d;
  seg_e             seg_q, seg_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             half_q, half_d;
  logic             done_q, done_d;

  logic             fd_in, capture;
  logic [4:0]       en_in;
  seg_e             seg_first, seg_next;
  logic [BIT_W-1:0] seg_len;
  logic [CMD_LW-1:0]  cmd_pos;
  logic [ADDR_LW-1:0] addr_pos;

  assign capture   = start && !run_q;
  assign fd_in     = full_duplex && tx_en && rx_en;
  assign en_in     = {rx_en && !fd_in, tx_en, dummy_en, addr_en, cmd_en};
  assign seg_first = first_seg(en_in, 0);
  assign seg_next  = first_seg(en_q, int'(seg_q) + 1);

  always_comb begin
    case (seg_q)
      SEG_CMD:   seg_len = BIT_W'(cmd_len_q);
      SEG_ADDR:  seg_len = BIT_W'(addr_len_q);
      SEG_DUMMY: seg_len = BIT_W'(dummy_len_q);
      SEG_TX:    seg_len = BIT_W'(tx_len_q);
      SEG_RX:    seg_len = BIT_W'(rx_len_q);
      default:   seg_len = '0;
    endcase
  end

  // Settings register, clock-enabled by an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_len_q   <= '0;
      cmd_val_q   <= '0;
      addr_len_q  <= '0;
      addr_val_q  <= '0;
      dummy_len_q <= '0;
      tx_len_q    <= '0;
      rx_len_q    <= '0;
      en_q        <= '0;
      fd_q        <= 1'b0;
      cpol_q      <= 1'b0;
      cpha_q      <= 1'b0;
      div_q       <= '0;
    end else if (capture) begin
      cmd_len_q   <= cmd_len_m1;
      cmd_val_q   <= cmd_val;
      addr_len_q  <= addr_len_m1;
      addr_val_q  <= addr_val;
      dummy_len_q <= dummy_len_m1;
      tx_len_q    <= tx_len_m1;
      rx_len_q    <= rx_len_m1;
      en_q        <= en_in;
      fd_q        <= fd_in;
      cpol_q      <= cpol;
      cpha_q      <= cpha;
      div_q       <= clk_div;
    end
  end

  // Next-state logic
  always_comb begin
    run_d  = run_q;
    seg_d  = seg_q;
    bit_d  = bit_q;
    half_d = half_q;
    done_d = 1'b0;
    if (!run_q) begin
      if (start) begin
        if (seg_first == SEG_NONE) begin
          done_d = 1'b1;
        end else begin
          run_d  = 1'b1;
          seg_d  = seg_first;
          bit_d  = '0;
          half_d = 1'b0;
        end
      end
    end else if (tick) begin
      if (!half_q) begin
        half_d = 1'b1;
      end else begin
        half_d = 1'b0;
        if (bit_q == seg_len) begin
          bit_d = '0;
          seg_d = seg_next;
          if (seg_next == SEG_NONE) begin
            run_d  = 1'b0;
            done_d = 1'b1;
          end
        end else begin
          bit_d = bit_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      seg_q  <= SEG_NONE;
      bit_q  <= '0;
      half_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      seg_q  <= seg_d;
      bit_q  <= bit_d;
      half_q <= half_d;
      done_q <= done_d;
    end
  end

  // Serial outputs
  assign cmd_pos  = cmd_len_q - bit_q[CMD_LW-1:0];
  assign addr_pos = addr_len_q - bit_q[ADDR_LW-1:0];

  always_comb begin
    case (seg_q)
      SEG_CMD:  mosi_o = run_q && cmd_val_q[cmd_pos];
      SEG_ADDR: mosi_o = run_q && addr_val_q[addr_pos];
      SEG_TX:   mosi_o = run_q && tx_word[~bit_q[WBIT_W-1:0]];
      default:  mosi_o = 1'b0;
    endcase
  end

  assign sclk_o    = run_q ? (cpol_q ^ (cpha_q ? !half_q : half_q)) : cpol;
  assign cs_n_o    = !run_q;
  assign run_o     = run_q;
  assign done_o    = done_q;
  assign div_o     = div_q;
  assign tx_idx_o  = bit_q[BIT_W-1:WBIT_W];
  assign sample_o  = run_q && tick && !half_q &&
                     ((seg_q == SEG_RX) || ((seg_q == SEG_TX) && fd_q));
  assign rx_bit_o  = bit_q;
  assign rx_last_o = (bit_q == seg_len);

  assert_seg_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> (3'(seg_q) >= 3'($past(seg_q))));

  assert_bit_in_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (bit_q <= seg_len));

  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && start) |=> ($stable(cmd_val_q) && $stable(addr_val_q) &&
                          $stable(en_q) && $stable(tx_len_q)));

  assert_end_gives_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> done_q);

endmodule

// File: rtl/spi_phase_master.sv
module spi_phase_master #(
  parameter int CMD_MAX   = 16,
  parameter int ADDR_MAX  = 32,
  parameter int DUMMY_MAX = 256,
  parameter int DATA_MAX  = 512,
  parameter int WORD_W    = 32,
  parameter int DIV_W     = 8,
  localparam int CMD_LW   = $clog2(CMD_MAX),
  localparam int ADDR_LW  = $clog2(ADDR_MAX),
  localparam int DUMMY_LW = $clog2(DUMMY_MAX),
  localparam int DATA_LW  = $clog2(DATA_MAX),
  localparam int WIDX_W   = DATA_LW - $clog2(WORD_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  output logic                busy,
  output logic                done,
  input  logic                cmd_en,
  input  logic [CMD_LW-1:0]   cmd_len_m1,
  input  logic [CMD_MAX-1:0]  cmd_val,
  input  logic                addr_en,
  input  logic [ADDR_LW-1:0]  addr_len_m1,
  input  logic [ADDR_MAX-1:0] addr_val,
  input  logic                dummy_en,
  input  logic [DUMMY_LW-1:0] dummy_len_m1,
  input  logic                tx_en,
  input  logic [DATA_LW-1:0]  tx_len_m1,
  input  logic                rx_en,
  input  logic [DATA_LW-1:0]  rx_len_m1,
  input  logic                full_duplex,
  input  logic [DIV_W-1:0]    clk_div,
  input  logic                cpol,
  input  logic                cpha,
  output logic [WIDX_W-1:0]   tx_word_idx,
  input  logic [WORD_W-1:0]   tx_word,
  output logic                rx_wr_en,
  output logic [WIDX_W-1:0]   rx_word_idx,
  output logic [WORD_W-1:0]   rx_word,
  output logic                sclk,
  output logic                cs_n,
  output logic                mosi,
  input  logic                miso
);

  logic [1:0]         rst_sync_q;
  logic               rst_n_int;
  logic               run, tick, sample, rx_last;
  logic [DIV_W-1:0]   div_lat;
  logic [DATA_LW-1:0] rx_bit;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  spi_seq_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk   (clk),
    .rst_n (rst_n_int),
    .run   (run),
    .div   (div_lat),
    .tick  (tick)
  );

  spi_seq_ctrl #(
    .CMD_MAX   (CMD_MAX),
    .ADDR_MAX  (ADDR_MAX),
    .DUMMY_MAX (DUMMY_MAX),
    .DATA_MAX  (DATA_MAX),
    .WORD_W    (WORD_W),
    .DIV_W     (DIV_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .start        (start),
    .cmd_en       (cmd_en),
    .cmd_len_m1   (cmd_len_m1),
    .cmd_val      (cmd_val),
    .addr_en      (addr_en),
    .addr_len_m1  (addr_len_m1),
    .addr_val     (addr_val),
    .dummy_en     (dummy_en),
    .dummy_len_m1 (dummy_len_m1),
    .tx_en        (tx_en),
    .tx_len_m1    (tx_len_m1),
    .rx_en        (rx_en),
    .rx_len_m1    (rx_len_m1),
    .full_duplex  (full_duplex),
    .clk_div      (clk_div),
    .cpol         (cpol),
    .cpha         (cpha),
    .tick         (tick),
    .tx_word      (tx_word),
    .div_o        (div_lat),
    .run_o        (run),
    .done_o       (done),
    .cs_n_o       (cs_n),
    .sclk_o       (sclk),
    .mosi_o       (mosi),
    .tx_idx_o     (tx_word_idx),
    .sample_o     (sample),
    .rx_bit_o     (rx_bit),
    .rx_last_o    (rx_last)
  );

  spi_seq_rxpack #(.BIT_W(DATA_LW), .WORD_W(WORD_W)) u_rxpack (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .sample  (sample),
    .miso    (miso),
    .bit_idx (rx_bit),
    .last    (rx_last),
    .wr_en   (rx_wr_en),
    .wr_idx  (rx_word_idx),
    .wr_word (rx_word)
  );

  assign busy = run;

  assert_sclk_moves_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n_int)
    (run && $past(run) && !$past(tick)) |-> $stable(sclk));

  assert_cs_release_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(cs_n) |-> done);

endmodule

// File: tb/tb_spi_phase_master.sv
module tb_spi_phase_master;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        busy, done;
  logic        cmd_en, addr_en, dummy_en, tx_en, rx_en, full_duplex;
  logic [3:0]  cmd_len_m1;
  logic [15:0] cmd_val;
  logic [4:0]  addr_len_m1;
  logic [31:0] addr_val;
  logic [7:0]  dummy_len_m1;
  logic [8:0]  tx_len_m1, rx_len_m1;
  logic [7:0]  clk_div;
  logic        cpol, cpha;
  logic [3:0]  tx_word_idx, rx_word_idx;
  logic [31:0] tx_word, rx_word;
  logic        rx_wr_en, sclk, cs_n, mosi, miso;

  always #2 clk = ~clk;

  spi_phase_master dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .cmd_en(cmd_en), .cmd_len_m1(cmd_len_m1), .cmd_val(cmd_val),
    .addr_en(addr_en), .addr_len_m1(addr_len_m1), .addr_val(addr_val),
    .dummy_en(dummy_en), .dummy_len_m1(dummy_len_m1),
    .tx_en(tx_en), .tx_len_m1(tx_len_m1), .rx_en(rx_en), .rx_len_m1(rx_len_m1),
    .full_duplex(full_duplex), .clk_div(clk_div), .cpol(cpol), .cpha(cpha),
    .tx_word_idx(tx_word_idx), .tx_word(tx_word),
    .rx_wr_en(rx_wr_en), .rx_word_idx(rx_word_idx), .rx_word(rx_word),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] txm [16];
  logic [31:0] rxm [16];
  assign tx_word = txm[tx_word_idx];

  function automatic logic patbit(input int g);
    return logic'((g ^ (g >> 2) ^ (g >> 5)) & 1);
  endfunction

  // Slave-side monitor
  bit   mon_on = 1'b0;
  logic samp_rise;
  int   ns, nedges, busy_cyc, done_cnt, cs_low, cs_rise, rx_writes;
  logic cs_prev;
  logic mbit [2048];

  assign miso = patbit(ns);

  always @(sclk) begin
    if (mon_on) begin
      nedges++;
      if (sclk == samp_rise && ns < 2048) begin
        mbit[ns] = mosi;
        ns++;
      end
    end
  end

  always @(negedge clk) begin
    if (mon_on) begin
      if (busy) busy_cyc++;
      if (done) done_cnt++;
      if (!cs_n) cs_low++;
      if (cs_n && !cs_prev) cs_rise++;
      cs_prev = cs_n;
      if (rx_wr_en) begin
        rxm[rx_word_idx] = rx_word;
        rx_writes++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // Expected values from the requirements
  logic        emos [2048];
  int          exp_n, exp_rxw;
  logic [31:0] erx [16];

  task automatic build_exp();
    int g, rxs, rxl, n;
    bit fd;
    g = 0; rxs = 0; rxl = 0;
    fd = full_duplex && tx_en && rx_en;
    if (cmd_en) begin
      n = int'(cmd_len_m1) + 1;
      for (int i = 0; i < n; i++) begin emos[g] = cmd_val[n-1-i]; g++; end
    end
    if (addr_en) begin
      n = int'(addr_len_m1) + 1;
      for (int i = 0; i < n; i++) begin emos[g] = addr_val[n-1-i]; g++; end
    end
    if (dummy_en) begin
      n = int'(dummy_len_m1) + 1;
      for (int i = 0; i < n; i++) begin emos[g] = 1'b0; g++; end
    end
    if (tx_en) begin
      n = int'(tx_len_m1) + 1;
      if (fd) begin rxs = g; rxl = n; end
      for (int i = 0; i < n; i++) begin emos[g] = txm[i/32][31 - (i%32)]; g++; end
    end
    if (rx_en && !fd) begin
      n = int'(rx_len_m1) + 1;
      rxs = g; rxl = n;
      for (int i = 0; i < n; i++) begin emos[g] = 1'b0; g++; end
    end
    exp_n = g;
    for (int w = 0; w < 16; w++) erx[w] = '0;
    for (int k = 0; k < rxl; k++) erx[k/32] = {erx[k/32][30:0], patbit(rxs + k)};
    exp_rxw = (rxl + 31) / 32;
  endtask

  task automatic cfg_clear();
    cmd_en = 0; addr_en = 0; dummy_en = 0; tx_en = 0; rx_en = 0; full_duplex = 0;
    cmd_len_m1 = 0; cmd_val = 0; addr_len_m1 = 0; addr_val = 0; dummy_len_m1 = 0;
    tx_len_m1 = 0; rx_len_m1 = 0;
  endtask

  task automatic set_mode(input logic pol, input logic pha, input logic [7:0] div);
    cpol = pol; cpha = pha; clk_div = div;
    samp_rise = ~(pol ^ pha);
  endtask

  // Runs one transaction and checks everything it observes.
  task automatic do_xfer(input string mos_tag, input string rx_tag, input bit poke);
    int bad, first_bad, wait_n;
    build_exp();
    for (int w = 0; w < 16; w++) rxm[w] = 32'hDEAD_0000;
    @(negedge clk);
    ns = 0; nedges = 0; busy_cyc = 0; done_cnt = 0; cs_low = 0; cs_rise = 0;
    rx_writes = 0; cs_prev = cs_n; mon_on = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == (exp_n > 0), "R11", "busy after start", longint'(busy), longint'(exp_n > 0));
    if (poke) begin
      repeat (20) @(negedge clk);
      cmd_val = ~cmd_val;
      tx_len_m1 = 9'd3;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_n = 0;
    while (done_cnt == 0 && wait_n < 60000) begin
      @(negedge clk);
      wait_n++;
    end
    if (done_cnt == 0) chk(1'b0, "R11", "watchdog waiting for done", 0, 1);
    repeat (6) @(negedge clk);
    mon_on = 1'b0;

    bad = 0; first_bad = -1;
    for (int i = 0; i < exp_n; i++) begin
      if (mbit[i] !== emos[i]) begin
        bad++;
        if (first_bad < 0) first_bad = i;
      end
    end
    chk(ns == exp_n, mos_tag, "sampled bit count", ns, exp_n);
    chk(bad == 0, mos_tag, "MOSI bits wrong (first index in actual)", first_bad, -1);
    chk(nedges == 2 * exp_n, "R8", "SCLK transitions", nedges, 2 * exp_n);
    chk(sclk == cpol, "R8", "SCLK idle level", longint'(sclk), longint'(cpol));
    chk(cs_low == busy_cyc && cs_rise == int'(exp_n > 0), "R8", "cs_n low span",
        cs_low, busy_cyc);
    chk(busy_cyc == 2 * (int'(clk_div) + 1) * exp_n, "R10", "busy cycles",
        busy_cyc, 2 * (int'(clk_div) + 1) * exp_n);
    chk(done_cnt == 1 && !busy, "R11", "done pulses", done_cnt, 1);
    chk(rx_writes == exp_rxw, rx_tag, "incoming word writes", rx_writes, exp_rxw);
    for (int w = 0; w < exp_rxw; w++)
      chk(rxm[w] == erx[w], rx_tag, $sformatf("incoming word %0d", w), rxm[w], erx[w]);
  endtask

  task automatic t_reset();
    chk(cs_n == 1'b1, "R8", "reset cs_n", cs_n, 1);
    chk(busy == 1'b0 && done == 1'b0, "R11", "reset busy/done", {busy, done}, 0);
    chk(sclk == cpol, "R8", "reset SCLK idle", sclk, cpol);
    chk(rx_wr_en == 1'b0 && mosi == 1'b0, "R6", "reset strobe/MOSI", {rx_wr_en, mosi}, 0);
  endtask

  task automatic t_mode0_cmd_addr_tx();
    cfg_clear(); set_mode(0, 0, 8'd1);
    cmd_en = 1; cmd_len_m1 = 4'd7; cmd_val = 16'h7FA5;
    addr_en = 1; addr_len_m1 = 5'd23; addr_val = 32'hFF12_3456;
    tx_en = 1; tx_len_m1 = 9'd15; txm[0] = 32'hC3A5_0F96;
    @(negedge clk);
    do_xfer("R2/R3/R5/R9", "R6", 0);
  endtask

  task automatic t_mode3_dummy_rx();
    cfg_clear(); set_mode(1, 1, 8'd2);
    dummy_en = 1; dummy_len_m1 = 8'd255;
    rx_en = 1; rx_len_m1 = 9'd39;
    @(negedge clk);
    do_xfer("R4/R9", "R6", 0);
  endtask

  task automatic t_mode1_full_duplex();
    cfg_clear(); set_mode(0, 1, 8'd0);
    tx_en = 1; tx_len_m1 = 9'd47; rx_en = 1; rx_len_m1 = 9'd5; full_duplex = 1;
    txm[0] = 32'h1357_9BDF; txm[1] = 32'h2468_ACE0;
    @(negedge clk);
    do_xfer("R5/R7", "R7/R9", 0);
  endtask

  task automatic t_mode2_all_segments();
    cfg_clear(); set_mode(1, 0, 8'd3);
    cmd_en = 1; cmd_len_m1 = 4'd15; cmd_val = 16'hBEEF;
    addr_en = 1; addr_len_m1 = 5'd31; addr_val = 32'hDEAD_BEEF;
    dummy_en = 1; dummy_len_m1 = 8'd0;
    tx_en = 1; tx_len_m1 = 9'd7; txm[0] = 32'h5A00_0000;
    rx_en = 1; rx_len_m1 = 9'd7;
    @(negedge clk);
    do_xfer("R1/R2/R3/R4", "R1/R6", 0);
  endtask

  task automatic t_start_while_busy();
    cfg_clear(); set_mode(0, 0, 8'd1);
    cmd_en = 1; cmd_len_m1 = 4'd7; cmd_val = 16'h003C;
    tx_en = 1; tx_len_m1 = 9'd31; txm[0] = 32'h8001_F00D;
    @(negedge clk);
    do_xfer("R11", "R11", 1);
  endtask

  task automatic t_nothing_enabled();
    cfg_clear(); set_mode(0, 0, 8'd1);
    @(negedge clk);
    do_xfer("R1", "R1", 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0;
    cfg_clear(); set_mode(0, 0, 8'd1);
    for (int w = 0; w < 16; w++) txm[w] = 32'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_mode0_cmd_addr_tx();
    t_mode3_dummy_rx();
    t_mode1_full_duplex();
    t_mode2_all_segments();
    t_start_while_busy();
    t_nothing_enabled();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule